// File: doc/BRIEF.md
# Memory-Mapped Signed Arithmetic Peripheral

This block is an AXI4-Lite slave with a 32-bit data path that exposes four word-sized registers. A host stores three signed operands, a, b and c, in the first three words. A fixed two-stage signed datapath runs all the time on those operands and produces d = 3 + c·c·(a + b), cut to 32 bits. The fourth word returns that result. The host never starts or polls the calculation. It writes the operands, lets two clock edges pass, and reads the answer.

The write address, write data and write response channels use valid/ready handshakes. Back-pressure works as follows:
- The slave accepts at most one address beat and one data beat per write. It lowers AWREADY or WREADY once it holds that beat.
- While a response is waiting for BREADY, the slave lowers both AWREADY and WREADY.
- The read address channel takes one request at a time. ARREADY stays low while RVALID is waiting for RREADY.
- The master may hold BREADY or RREADY low for as long as it likes. The response stays valid and unchanged until the handshake completes.

Top module: `arith_mmio`

## Requirements
- R1: Bits [3:2] of the byte address select the word: 0 is operand a, 1 is b, 2 is c and 3 is the result d. Bits [1:0] are ignored. Each operand word reads back the last value written to it.
- R2: The result word returns 3 + c·c·(a + b), computed as signed two's complement and cut to 32 bits. For a=4, b=-9, c=2 it returns -17 (0xFFFFFFEF). For a=12, b=-50, c=12 it returns -5469. For a=13, b=13, c=13 it returns 4397.
- R3: The result is a pipeline with two register stages. The edge on which a write commits is edge 0. A read whose address handshake happens on edge 2 still returns the result from the old operands. A read whose handshake happens on edge 3 or later returns the result from the new operands.
- R4: The write address and write data beats may arrive in either order or in the same cycle. BVALID rises only after both beats have been accepted, and BRESP is always 00 (OKAY).
- R5: Once BVALID is high, it stays high until the cycle in which BREADY is sampled high. While it is high, AWREADY and WREADY are low.
- R6: On the operand words, WSTRB bit i enables write-data byte i (bits 8i+7 to 8i). Bytes whose strobe bit is 0 keep their old value, and a strobe of 0000 changes nothing.
- R7: A write to word 3 completes with an OKAY response. It changes neither the operands nor the result.
- R8: RRESP is always 00 (OKAY). RDATA stays stable while RVALID is high and RREADY is low. ARREADY is low while a read response is outstanding.
- R9: The synchronous active-low reset clears the operands and both pipeline stages and lowers BVALID and RVALID. Once the reset is released and the pipeline has refilled, the result word reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| awaddr | input | 4 | Write byte address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response code |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | 4 | Read byte address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response ready |

## Verification
The hardest case to reach from the ports is the latency boundary of the result word. A read must land its address handshake exactly two or exactly three edges after a write commits, because only those two reads show whether the pipeline depth is right. The bench counts clock edges from the commit edge of an operand write. It then issues one read that lands on edge 2 and expects the old result, and a second read after a fresh write that lands on edge 3 and expects the new result. It also drives write beats in all three arrival orders and holds BREADY and RREADY low for several cycles, so that the held-response paths are exercised.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned NUM_OPS = 3;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [SEL_W-1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2,
    SEL_D = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lite_wr_chan.sv
module lite_wr_chan
  import arith_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   awaddr,
  input  logic            awvalid,
  output logic            awready,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wstrb,
  input  logic            wvalid,
  output logic            wready,
  output logic [1:0]      bresp,
  output logic            bvalid,
  input  logic            bready,
  output logic            wr_en,
  output logic [SEL_W-1:0] wr_sel,
  output logic [DW-1:0]   wr_data,
  output logic [DW/8-1:0] wr_strb
);
  localparam int unsigned LSB = $clog2(DW/8);

  logic            aw_got, w_got, bv_q;
  logic [AW-1:0]   aw_q;
  logic [DW-1:0]   data_q;
  logic [DW/8-1:0] strb_q;
  logic            aw_fire, w_fire;
  logic [AW-1:0]   addr_use;

  assign awready = !aw_got && !bv_q;
  assign wready  = !w_got && !bv_q;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign wr_en   = (aw_got || aw_fire) && (w_got || w_fire);
  assign addr_use = aw_got ? aw_q : awaddr;
  assign wr_sel  = addr_use[LSB +: SEL_W];
  assign wr_data = w_got ? data_q : wdata;
  assign wr_strb = w_got ? strb_q : wstrb;
  assign bvalid  = bv_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_got <= 1'b0;
      w_got  <= 1'b0;
      bv_q   <= 1'b0;
      aw_q   <= '0;
      data_q <= '0;
      strb_q <= '0;
    end else begin
      if (aw_fire && !wr_en) begin
        aw_got <= 1'b1;
        aw_q   <= awaddr;
      end
      if (w_fire && !wr_en) begin
        w_got  <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (wr_en) begin
        aw_got <= 1'b0;
        w_got  <= 1'b0;
        bv_q   <= 1'b1;
      end else if (bv_q && bready) begin
        bv_q <= 1'b0;
      end
    end
  end

  // R5: a pending response is held and blocks a new commit
  assert_bresp_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && !wr_en));
  // R4: a commit always raises the response
  assert_commit_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bvalid);
endmodule

// File: rtl/lite_rd_chan.sv
module lite_rd_chan
  import arith_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    araddr,
  input  logic             arvalid,
  output logic             arready,
  output logic [DW-1:0]    rdata,
  output logic [1:0]       rresp,
  output logic             rvalid,
  input  logic             rready,
  output logic [SEL_W-1:0] rd_sel,
  input  logic [DW-1:0]    rd_word
);
  localparam int unsigned LSB = $clog2(DW/8);

  logic          rv_q;
  logic [DW-1:0] rdata_q;

  assign arready = !rv_q;
  assign rd_sel  = araddr[LSB +: SEL_W];
  assign rvalid  = rv_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rdata_q <= '0;
    end else if (arvalid && arready) begin
      rv_q    <= 1'b1;
      rdata_q <= rd_word;
    end else if (rv_q && rready) begin
      rv_q <= 1'b0;
    end
  end

  // R8: response data frozen under back-pressure
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  assert_ar_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready) |=> rvalid);
endmodule

// File: rtl/oper_regs.sv
module oper_regs
  import arith_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NOPS = NUM_OPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW/8-1:0]  wr_strb,
  output logic [DW-1:0]    op_a,
  output logic [DW-1:0]    op_b,
  output logic [DW-1:0]    op_c
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] regs [NOPS];

  for (genvar r = 0; r < NOPS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[r] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(r))) begin
        for (int j = 0; j < NB; j++) begin
          if (wr_strb[j]) regs[r][8*j +: 8] <= wr_data[8*j +: 8];
        end
      end
    end
  end

  assign op_a = regs[0];
  assign op_b = regs[1];
  assign op_c = regs[2];

  // R7: the result slot is not storage
  assert_result_slot_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_D) |=> ($stable(op_a) && $stable(op_b) && $stable(op_c)));
  // R6: an all-zero strobe changes nothing
  assert_zero_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_strb == '0) |=> ($stable(op_a) && $stable(op_b) && $stable(op_c)));
endmodule

// File: rtl/arith_pipe.sv
module arith_pipe
  import arith_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int          ADD_C = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] op_c,
  output logic [DW-1:0] res_d
);
  localparam logic signed [DW-1:0] KADD = DW'(ADD_C);

  logic signed [DW-1:0] c_sq_q, sum_q, d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_sq_q <= '0;
      sum_q  <= '0;
      d_q    <= '0;
    end else begin
      c_sq_q <= $signed(op_c) * $signed(op_c);
      sum_q  <= $signed(op_a) + $signed(op_b);
      d_q    <= KADD + c_sq_q * sum_q;
    end
  end

  assign res_d = d_q;
endmodule

// File: rtl/arith_mmio.sv
module arith_mmio
  import arith_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int          ADD_C = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   awaddr,
  input  logic            awvalid,
  output logic            awready,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wstrb,
  input  logic            wvalid,
  output logic            wready,
  output logic [1:0]      bresp,
  output logic            bvalid,
  input  logic            bready,
  input  logic [AW-1:0]   araddr,
  input  logic            arvalid,
  output logic            arready,
  output logic [DW-1:0]   rdata,
  output logic [1:0]      rresp,
  output logic            rvalid,
  input  logic            rready
);
  localparam logic [DW-1:0] KCHK = DW'(ADD_C);

  logic             wr_en;
  logic [SEL_W-1:0] wr_sel, rd_sel;
  logic [DW-1:0]    wr_data, op_a, op_b, op_c, res_d, rd_word;
  logic [DW/8-1:0]  wr_strb;

  lite_wr_chan #(.AW(AW), .DW(DW)) u_wr (
    .clk, .rst_n, .awaddr, .awvalid, .awready, .wdata, .wstrb, .wvalid,
    .wready, .bresp, .bvalid, .bready, .wr_en, .wr_sel, .wr_data, .wr_strb
  );

  oper_regs #(.DW(DW), .NOPS(NUM_OPS)) u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .wr_strb, .op_a, .op_b, .op_c
  );

  arith_pipe #(.DW(DW), .ADD_C(ADD_C)) u_pipe (
    .clk, .rst_n, .op_a, .op_b, .op_c, .res_d
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_A:   rd_word = op_a;
      SEL_B:   rd_word = op_b;
      SEL_C:   rd_word = op_c;
      default: rd_word = res_d;
    endcase
  end

  lite_rd_chan #(.AW(AW), .DW(DW)) u_rd (
    .clk, .rst_n, .araddr, .arvalid, .arready, .rdata, .rresp, .rvalid,
    .rready, .rd_sel, .rd_word
  );

  // edges since the last commit, saturating at the pipeline depth
  logic [1:0] quiet;
  always_ff @(posedge clk) begin
    if (!rst_n || wr_en) quiet <= '0;
    else if (quiet != 2'd2) quiet <= quiet + 2'd1;
  end

  // R2, R3: two quiet edges after any commit the result matches the operands
  assert_result_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet == 2'd2) |-> (res_d == KCHK + op_c * op_c * (op_a + op_b)));
endmodule

// File: tb/sim_arith_mmio.sv
module sim_arith_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
  logic        arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;
  int ma = 0, mb = 0, mc = 0;

  always #4 clk = ~clk;

  arith_mmio u0 (
    .clk, .rst_n, .awaddr, .awvalid, .awready, .wdata, .wstrb, .wvalid,
    .wready, .bresp, .bvalid, .bready, .araddr, .arvalid, .arready,
    .rdata, .rresp, .rvalid, .rready
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int fres(input int a, input int b, input int c);
    return 3 + c * c * (a + b);
  endfunction

  always @(posedge clk) cyc++;

  // per-clock response code checks
  always @(negedge clk) begin
    if (rst_n && bvalid) check(bresp == 2'b00, "R4 bresp", 32'(bresp), 0);
    if (rst_n && rvalid) check(rresp == 2'b00, "R8 rresp", 32'(rresp), 0);
  end

  // order: 0 together, 1 address first, 2 data first. Enters and leaves at negedge.
  task automatic wr(input logic [3:0] addr, input logic [31:0] data,
                    input logic [3:0] strb, input int order, input int bhold);
    bit aw_done = 1'b0, w_done = 1'b0;
    if (order != 2) begin awvalid = 1'b1; awaddr = addr; end
    if (order != 1) begin wvalid = 1'b1; wdata = data; wstrb = strb; end
    while (!(aw_done && w_done)) begin
      bit aw_acc, w_acc;
      aw_acc = awvalid && awready;
      w_acc  = wvalid && wready;
      @(posedge clk); @(negedge clk);
      if (aw_acc) begin aw_done = 1'b1; awvalid = 1'b0; end
      if (w_acc)  begin w_done  = 1'b1; wvalid  = 1'b0; end
      if (aw_done && !w_done && !wvalid) begin
        check(!bvalid, "R4 no response before data", 32'(bvalid), 0);
        wvalid = 1'b1; wdata = data; wstrb = strb;
      end
      if (w_done && !aw_done && !awvalid) begin
        check(!bvalid, "R4 no response before address", 32'(bvalid), 0);
        awvalid = 1'b1; awaddr = addr;
      end
    end
    check(bvalid, "R4 response after both beats", 32'(bvalid), 1);
    for (int i = 0; i < bhold; i++) begin
      @(posedge clk); @(negedge clk);
      check(bvalid && !awready && !wready, "R5 response held",
            {bvalid, awready, wready}, 32'b100);
    end
    bready = 1'b1;
    @(posedge clk); @(negedge clk);
    bready = 1'b0;
    check(!bvalid, "R5 response released", 32'(bvalid), 0);
    if (addr[3:2] != 2'd3) begin
      int v;
      case (addr[3:2]) 2'd0: v = ma; 2'd1: v = mb; default: v = mc; endcase
      for (int j = 0; j < 4; j++) if (strb[j]) v[8*j +: 8] = data[8*j +: 8];
      case (addr[3:2]) 2'd0: ma = v; 2'd1: mb = v; default: mc = v; endcase
    end
  endtask

  task automatic rd(input logic [3:0] addr, input int hold, output logic [31:0] data);
    logic [31:0] first;
    arvalid = 1'b1; araddr = addr;
    forever begin
      bit acc;
      acc = arready;
      @(posedge clk); @(negedge clk);
      if (acc) break;
    end
    arvalid = 1'b0;
    first = rdata;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk);
      check(rvalid && rdata == first && !arready, "R8 read held", rdata, first);
    end
    data = rdata;
    rready = 1'b1;
    @(posedge clk); @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(4'h0, 0, v); check(v == ma, {tag, " R1 a"}, v, ma);
    rd(4'h4, 0, v); check(v == mb, {tag, " R1 b"}, v, mb);
    rd(4'h8, 0, v); check(v == mc, {tag, " R1 c"}, v, mc);
    rd(4'hC, 0, v); check(v == fres(ma, mb, mc), {tag, " R2 d"}, v, fres(ma, mb, mc));
  endtask

  initial begin
    int cnt = 0;
    while (!finished && cnt < 20000) begin @(posedge clk); cnt++; end
    if (!finished) begin
      check(1'b0, "watchdog", 32'(cnt), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check(!bvalid && !rvalid && awready && wready && arready, "R9 reset outputs",
          {bvalid, rvalid, awready, wready, arready}, 32'b00111);
    idle(3);
    rd(4'hC, 0, v); check(v == 32'd3, "R9 result after reset", v, 3);
    rd(4'h8, 0, v); check(v == 32'd0, "R9 operand cleared", v, 0);

    wr(4'h0, 32'd4, 4'hF, 0, 0);
    wr(4'h4, -32'sd9, 4'hF, 1, 2);
    wr(4'h8, 32'd2, 4'hF, 2, 0);
    idle(3);
    rd(4'hC, 0, v); check(v == 32'hFFFFFFEF, "R2 example one", v, 32'hFFFFFFEF);
    check_all("ex1");

    wr(4'h0, 32'd12, 4'hF, 2, 1);
    wr(4'h4, -32'sd50, 4'hF, 0, 0);
    wr(4'h8, 32'd12, 4'hF, 1, 0);
    idle(3);
    rd(4'hC, 3, v); check(v == -32'sd5469, "R2 example two", v, -32'sd5469);

    wr(4'h0, 32'd13, 4'hF, 0, 0);
    wr(4'h4, 32'd13, 4'hF, 0, 0);
    wr(4'h8, 32'd13, 4'hF, 0, 0);
    idle(3);
    rd(4'hC, 0, v); check(v == 32'd4397, "R2 example three", v, 4397);

    wr(4'h5, 32'd77, 4'hF, 0, 0);
    rd(4'h7, 0, v); check(v == 32'd77, "R1 low address bits ignored", v, 77);

    wr(4'h8, 32'hAABBCCDD, 4'b0101, 1, 0);
    rd(4'h8, 0, v); check(v == mc, "R6 partial strobe", v, mc);
    wr(4'h0, 32'hDEADBEEF, 4'b0000, 0, 0);
    rd(4'h0, 0, v); check(v == 32'd13, "R6 zero strobe", v, 13);
    idle(2);
    check_all("strobe");

    wr(4'hC, 32'h12345678, 4'hF, 0, 1);
    idle(2);
    check_all("R7 result write ignored");

    wr(4'h0, 32'h7FFFFFFF, 4'hF, 0, 0);
    wr(4'h4, 32'd1, 4'hF, 0, 0);
    wr(4'h8, 32'h00010003, 4'hF, 0, 0);
    idle(3);
    check_all("wrap");

    wr(4'h0, 32'd1, 4'hF, 0, 0);
    wr(4'h4, 32'd1, 4'hF, 0, 0);
    wr(4'h8, 32'd1, 4'hF, 0, 0);
    idle(3);
    // commit edge is edge 0; wr leaves one edge later, so this handshake is edge 2
    wr(4'h8, 32'd3, 4'hF, 0, 0);
    rd(4'hC, 0, v); check(v == 32'd5, "R3 old result at edge 2", v, 5);
    idle(3);
    wr(4'h8, 32'd4, 4'hF, 0, 0);
    idle(1);
    rd(4'hC, 0, v); check(v == 32'd35, "R3 new result at edge 3", v, 35);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule